// File: doc/BRIEF.md
# Power Manager Interrupt Aggregator

This block gathers seven event lines from a power manager into a small interrupt unit. Each event line can be a short pulse or a held level. Its rising edge latches a pending flag in a cause register. A mask register selects which pending flags may reach the single summary interrupt output, and that output drives an upstream interrupt controller.

Software reaches both registers through a simple 32-bit memory-mapped port. The cause register is plain read/write and is not write-zero-to-clear. Software clears a flag by writing the register back with that bit low, and it can raise an interrupt by writing a 1. A helper output gives the number of the highest pending enabled source, with a valid flag, so that a handler can service sources from the top down. Initialisation writes zero to the mask and the cause, which disables and clears every source.

Top module: `pm_irq_agg`

## Requirements
- R1: After reset the cause and mask registers read as zero, `irq_o` is low and `prio_vld_o` is low.
- R2: A rising edge on `evt_i[k]` (low in one cycle, high at the next clock edge) sets cause bit k at that clock edge. A level that stays high sets the bit only once, so after software clears the bit it stays clear until the input falls and rises again.
- R3: Writing to byte offset 0x50 loads cause bits 6..0 from `wdata_i[6:0]`. A written 1 raises that source and a written 0 clears it.
- R4: Writing to byte offset 0x54 loads mask bits 6..0 from `wdata_i[6:0]`. A mask bit of 1 enables its source and a 0 blocks it.
- R5: When a rising edge and a software write of 0 hit the same cause bit in the same cycle, the bit ends up set.
- R6: `irq_o` is a register. It is high in the cycle after any bit of (cause AND mask) is set, and low in the cycle after none is set.
- R7: `prio_vld_o` is high exactly when (cause AND mask) is nonzero. In that case `prio_idx_o` gives the highest-numbered set bit of (cause AND mask) as a 3-bit binary number.
- R8: Bits 31..7 of both registers always read as zero. Writing to them has no effect.
- R9: A read (`req_i`=1, `we_i`=0) updates `rdata_o` at the next clock edge, and `rdata_o` holds its value at all other times. Reads from offsets other than 0x50 and 0x54 return zero, and writes to those offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event lines from the power manager, pulse or level |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Summary interrupt to the upstream controller |
| prio_idx_o | output | 3 | Highest pending enabled source |
| prio_vld_o | output | 1 | High when any enabled source is pending |

## Verification
The two functions that can collide are the latching of a hardware edge and a software write to the cause register. Both can land on the same bit at the same clock edge, and the block must keep the flag set. The bench provokes this with a directed case: it drives a rising edge on bit 0 and a cause write of zero in the same cycle, then reads the bit back and expects it set. A long randomised stretch then mixes event toggles with cause and mask writes, so that many more collisions occur. In that stretch a behavioural model judges the interrupt, the priority outputs and the read data on every cycle.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  localparam int unsigned NUM_SRC   = 7;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam logic [7:0]  CAUSE_OFS = 8'h50;
  localparam logic [7:0]  MASK_OFS  = 8'h54;
endpackage

// File: rtl/pm_irq_edge.sv
module pm_irq_edge #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_q_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end

  assign lvl_q_o = lvl_q;
endmodule

// File: rtl/pm_irq_regs.sv
module pm_irq_regs #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic         wr_cause_i,
  input  logic         wr_mask_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] cause_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] cause_q, cause_d;
  logic [N-1:0] mask_q;

  // hardware set overrides a software clear of the same bit
  always_comb begin
    cause_d = wr_cause_i ? wdata_i : cause_q;
    cause_d = cause_d | rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_d;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/pm_irq_prio.sv
module pm_irq_prio #(
  parameter int unsigned N     = 7,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  // ascending scan: the last hit is the highest bit
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign vld_o = |pend_i;
endmodule

// File: rtl/pm_irq_agg.sv
module pm_irq_agg #(
  parameter int unsigned NUM_SRC   = pm_irq_pkg::NUM_SRC,
  parameter int unsigned DATA_W    = pm_irq_pkg::DATA_W,
  parameter int unsigned ADDR_W    = pm_irq_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = ADDR_W'(pm_irq_pkg::CAUSE_OFS),
  parameter logic [ADDR_W-1:0] MASK_OFS  = ADDR_W'(pm_irq_pkg::MASK_OFS),
  localparam int unsigned IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   prio_idx_o,
  output logic               prio_vld_o
);
  logic [NUM_SRC-1:0] evt_q, rise;
  logic [NUM_SRC-1:0] cause_q, mask_q, pend;
  logic               sel_cause, sel_mask, wr_cause, wr_mask, rd_en;
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic               irq_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

  assign sel_cause = (addr_i == CAUSE_OFS);
  assign sel_mask  = (addr_i == MASK_OFS);
  assign wr_cause  = req_i & we_i & sel_cause;
  assign wr_mask   = req_i & we_i & sel_mask;
  assign rd_en     = req_i & ~we_i;

  pm_irq_edge #(.N(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (evt_i),
    .lvl_q_o(evt_q),
    .rise_o (rise)
  );

  pm_irq_regs #(.N(NUM_SRC)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .wr_cause_i(wr_cause),
    .wr_mask_i (wr_mask),
    .wdata_i   (wdata_i[NUM_SRC-1:0]),
    .cause_o   (cause_q),
    .mask_o    (mask_q)
  );

  assign pend = cause_q & mask_q;

  pm_irq_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i(pend),
    .idx_o (prio_idx_o),
    .vld_o (prio_vld_o)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_cause)     rd_mux = DATA_W'(cause_q);
    else if (sel_mask) rd_mux = DATA_W'(mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_mux;
      irq_q <= |pend;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pm_irq_agg_chk.sv
module pm_irq_agg_chk #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h54,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [NUM_SRC-1:0] evt_q,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [IDX_W-1:0]   prio_idx_o,
  input logic               prio_vld_o
);
  logic [NUM_SRC-1:0] pend, edges;
  logic               wr_c, wr_m, rd;

  assign pend  = cause_q & mask_q;
  assign edges = evt_i & ~evt_q;
  assign wr_c  = req_i & we_i & (addr_i == CAUSE_OFS);
  assign wr_m  = req_i & we_i & (addr_i == MASK_OFS);
  assign rd    = req_i & ~we_i;

  p_rise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edges) |=> ((cause_q & $past(edges)) == $past(edges)));

  // R5: a coinciding edge survives the write
  p_cause_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_c |=> (cause_q == ($past(wdata_i[NUM_SRC-1:0]) | $past(edges))));

  p_mask_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_m |=> (mask_q == $past(wdata_i[NUM_SRC-1:0])));

  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_vld_o |=> irq_o);

  p_irq_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prio_vld_o |=> !irq_o);

  p_vld_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_vld_o == (pend != '0));

  p_idx_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_vld_o |-> ((pend >> prio_idx_o) == NUM_SRC'(1)));

  p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_SRC] == '0);

  p_mask_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_m |=> $stable(mask_q));

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

bind pm_irq_agg pm_irq_agg_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .evt_q(evt_q),
  .cause_q(cause_q), .mask_q(mask_q), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .prio_idx_o(prio_idx_o), .prio_vld_o(prio_vld_o)
);

// File: tb/tb_pm_irq_agg.sv
`timescale 1ns/1ps
module tb_pm_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, vld;
  logic [2:0]  idx;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_irq_agg dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .prio_idx_o(idx), .prio_vld_o(vld)
  );

  // behavioural reference
  bit [6:0]  m_cause, m_mask, m_evt;
  bit        m_irq;
  bit [31:0] m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause <= 0; m_mask <= 0; m_evt <= 0; m_irq <= 0; m_rdata <= 0;
    end else begin
      bit [6:0] nc;
      nc = m_cause;
      if (req && we && addr == 8'h50) nc = wdata[6:0];
      for (int i = 0; i < 7; i++) if (evt[i] && !m_evt[i]) nc[i] = 1'b1;
      if (req && we && addr == 8'h54) m_mask <= wdata[6:0];
      if (req && !we)
        m_rdata <= (addr == 8'h50) ? {25'd0, m_cause} :
                   (addr == 8'h54) ? {25'd0, m_mask} : 32'd0;
      m_irq   <= (m_cause & m_mask) != 0;
      m_cause <= nc;
      m_evt   <= evt;
    end
  end

  function automatic int top_bit(bit [6:0] v);
    int r = -1;
    for (int i = 0; i < 7; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(string req_id, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_id, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    int t;
    t = top_bit(m_cause & m_mask);
    chk("R6 irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R7 vld", {31'd0, vld}, {31'd0, t >= 0});
    if (t >= 0) chk("R7 idx", {29'd0, idx}, t[31:0]);
    chk("R9 rdata", rdata, m_rdata);
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic pulse(int k);
    evt[k] = 1'b1;
    @(negedge clk);
    evt[k] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 vld", {31'd0, vld}, 0);
    bus_rd(8'h50, d); chk("R1 cause", d, 0);
    bus_rd(8'h54, d); chk("R1 mask", d, 0);
    // R4, R8
    bus_wr(8'h54, 32'hFFFF_FFFF);
    bus_rd(8'h54, d); chk("R4/R8 mask", d, 32'h7F);
    // R2, R7, R6
    pulse(3);
    bus_rd(8'h50, d); chk("R2 cause", d, 32'h08);
    chk("R7 idx3", {29'd0, idx}, 3);
    chk("R6 irq", {31'd0, irq}, 1);
    pulse(5); pulse(1);
    chk("R7 idx5", {29'd0, idx}, 5);
    // R3 clear and software set
    bus_wr(8'h50, 32'h0);
    @(negedge clk);
    chk("R6 irq low", {31'd0, irq}, 0);
    bus_wr(8'h50, 32'hFFFF_FF40);
    bus_rd(8'h50, d); chk("R3/R8 cause", d, 32'h40);
    chk("R7 idx6", {29'd0, idx}, 6);
    // R4 blocking
    bus_wr(8'h54, 32'h3F);
    @(negedge clk);
    chk("R4 vld", {31'd0, vld}, 0);
    chk("R4 irq", {31'd0, irq}, 0);
    bus_wr(8'h54, 32'h7F);
    bus_wr(8'h50, 32'h0);
    // R2 level held
    evt[2] = 1'b1;
    @(negedge clk);
    bus_wr(8'h50, 32'h0);
    @(negedge clk);
    bus_rd(8'h50, d); chk("R2 level once", d, 0);
    evt[2] = 1'b0;
    @(negedge clk);
    // R5 collision
    evt[0] = 1'b1;
    bus_wr(8'h50, 32'h0);
    evt[0] = 1'b0;
    bus_rd(8'h50, d); chk("R5 hw wins", d, 32'h01);
    // R9 other offset
    bus_wr(8'h58, 32'h7F);
    bus_rd(8'h58, d); chk("R9 other rd", d, 0);
    bus_rd(8'h54, d); chk("R9 mask kept", d, 32'h7F);
    bus_rd(8'h50, d); chk("R9 cause kept", d, 32'h01);
    // randomised mix
    for (int c = 0; c < 3000; c++) begin
      int op;
      op = $urandom_range(0, 7);
      evt = 7'($urandom);
      req = 0; we = 0;
      if (op < 3) begin
        req = 1; we = 1;
        addr = (op == 0) ? 8'h50 : (op == 1) ? 8'h54 : 8'h58;
        wdata = $urandom;
      end else if (op < 6) begin
        req = 1;
        addr = (op == 3) ? 8'h50 : (op == 4) ? 8'h54 : 8'h5C;
      end
      @(negedge clk);
    end
    req = 0; we = 0; evt = '0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule